// File: doc/BRIEF.md
# USB LPM Device Response Logic

This block sits beside the token decoder of a USB device controller. It decides how the device answers a Link Power Management token and records the outcome in an 8-bit raw interrupt status word. A decoded token arrives as a one-cycle strobe with its link-state field. The answer is chosen from four things: a 2-bit enable mode, a transmit-LPM control bit, the occupancy flags of the transmit and receive FIFOs, and whether the requested link state is supported.

The answer is a single-cycle one-hot handshake pulse (ACK, NYET or STALL). It appears in the cycle after the token strobe, together with a pulse that tells the attribute register to capture the token payload. Each outcome sets its own sticky bit in the status word. A resume event also sets a bit. Reading the status word clears it. An interrupt line is high while any status bit is set.

Top module: `lpm_dev_resp`

## Requirements
- R1: After reset the status word, the interrupt and all handshake and capture outputs are 0. Status bits 7:6 always read 0.
- R2: A read strobe clears the whole status word at the next clock edge. A bit set by an event at that same edge stays set. A bit that is not read stays set.
- R3: In mode 1 (lpm_mode = 2'b01), a token with link state 4'h1 is answered with STALL and sets status bit 0.
- R4: In mode 3, with the transmit-LPM bit at 0, a supported token is answered with NYET and sets status bit 1.
- R5: In mode 3, with the transmit-LPM bit at 1 and both FIFOs empty, a supported token is answered with ACK and sets status bit 2.
- R6: In mode 3, with the transmit-LPM bit at 1, no TX data and RX data pending, the answer is NYET and status bit 3 (no-completion) is set instead of bit 2.
- R7: In mode 3, with the transmit-LPM bit at 1 and TX data pending, the answer is NYET and status bit 1 is set, whatever the RX state.
- R8: In mode 1 or 3, a token whose link state is not 4'h1 is answered with STALL and sets status bit 5. No other status bit is set.
- R9: In mode 0 or 2, a token gives no handshake, no capture pulse and no status change.
- R10: A resume event sets status bit 4 at the next clock edge.
- R11: The interrupt output is high exactly when any status bit is set.
- R12: A handshake and the capture pulse each last one cycle, in the cycle after the token in mode 1 or 3. At most one handshake output is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lpm_rx_vld | input | 1 | One-cycle strobe for a decoded LPM token |
| lpm_link_state | input | 4 | Link-state field of the token |
| lpm_mode | input | 2 | LPM enable mode |
| lpm_tx_en | input | 1 | Transmit-LPM control bit |
| tx_fifo_busy | input | 1 | TX FIFO holds data |
| rx_fifo_busy | input | 1 | RX FIFO holds data |
| resume_evt | input | 1 | Resume event pulse |
| stat_rd | input | 1 | Status word read strobe |
| hs_ack | output | 1 | ACK handshake pulse |
| hs_nyet | output | 1 | NYET handshake pulse |
| hs_stall | output | 1 | STALL handshake pulse |
| attr_capture | output | 1 | Capture pulse for the attribute register |
| stat_q | output | 8 | Raw interrupt status word |
| irq | output | 1 | Any status bit set |

## Verification
The assertions check on every cycle the invariants that stand on their own: at most one handshake at a time, each handshake backed by its status bit, a capture pulse after every token in an active mode, silence in modes 0 and 2, resume setting its bit, and bits staying set unless read. The bench's scenarios cover the parts that depend on exact input combinations. These are the choice of bit under each FIFO combination, every unsupported link-state value in both active modes, and a read that lands in the same cycle as a new event. They are compared cycle by cycle against a behavioural model.

// File: rtl/lpm_dev_resp.sv
module lpm_dev_resp #(
  parameter int              LS_W  = 4,
  parameter logic [LS_W-1:0] LS_OK = 4'h1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lpm_rx_vld,
  input  logic [LS_W-1:0] lpm_link_state,
  input  logic [1:0]      lpm_mode,
  input  logic            lpm_tx_en,
  input  logic            tx_fifo_busy,
  input  logic            rx_fifo_busy,
  input  logic            resume_evt,
  input  logic            stat_rd,
  output logic            hs_ack,
  output logic            hs_nyet,
  output logic            hs_stall,
  output logic            attr_capture,
  output logic [7:0]      stat_q,
  output logic            irq
);

  localparam int NB = 6;
  localparam int B_STALL = 0, B_NYET = 1, B_ACK = 2, B_NOCMP = 3, B_RES = 4, B_ERR = 5;

  logic          take;
  logic [NB-1:0] set_v, stat_r;
  logic [2:0]    hs_d, hs_q;
  logic          cap_q;

  // mode 1 and mode 3 both have bit 0 set; modes 0 and 2 ignore tokens
  assign take = lpm_rx_vld & lpm_mode[0];

  always_comb begin
    set_v = '0;
    hs_d  = '0;
    set_v[B_RES] = resume_evt;
    if (take) begin
      if (lpm_link_state != LS_OK) begin
        hs_d[0] = 1'b1;
        set_v[B_ERR] = 1'b1;
      end else if (!lpm_mode[1]) begin
        hs_d[0] = 1'b1;
        set_v[B_STALL] = 1'b1;
      end else if (!lpm_tx_en || tx_fifo_busy) begin
        hs_d[1] = 1'b1;
        set_v[B_NYET] = 1'b1;
      end else if (rx_fifo_busy) begin
        hs_d[1] = 1'b1;
        set_v[B_NOCMP] = 1'b1;
      end else begin
        hs_d[2] = 1'b1;
        set_v[B_ACK] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_r <= '0;
      hs_q   <= '0;
      cap_q  <= 1'b0;
    end else begin
      stat_r <= (stat_rd ? '0 : stat_r) | set_v;
      hs_q   <= hs_d;
      cap_q  <= take;
    end
  end

  assign hs_stall     = hs_q[0];
  assign hs_nyet      = hs_q[1];
  assign hs_ack       = hs_q[2];
  assign attr_capture = cap_q;
  assign stat_q       = {2'b00, stat_r};
  assign irq          = |stat_r;

  assert_hs_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hs_ack, hs_nyet, hs_stall}));

  assert_capture_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (lpm_rx_vld && lpm_mode[0]) |=> (attr_capture && (hs_ack || hs_nyet || hs_stall)));

  assert_idle_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lpm_rx_vld && !lpm_mode[0]) |=> !(hs_ack || hs_nyet || hs_stall || attr_capture));

  assert_ack_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hs_ack |-> stat_q[2]);

  assert_stall_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hs_stall |-> (stat_q[0] || stat_q[5]));

  assert_resume_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resume_evt |=> stat_q[4]);

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_read_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !lpm_rx_vld && !resume_evt) |=> (stat_q == 8'h00));

endmodule

// File: tb/sim_lpm_dev_resp.sv
module sim_lpm_dev_resp;
  logic clk = 0, rst_n = 0;
  logic vld = 0, tx_en = 0, txb = 0, rxb = 0, res = 0, rd = 0;
  logic [3:0] ls = 4'h1;
  logic [1:0] mode = 2'd0;
  logic ack, nyet, stall, cap, irq;
  logic [7:0] stat;

  int checks = 0, fails = 0, cyc = 0;
  string cur = "R1";

  // behavioural model state
  bit [7:0] m_stat;
  bit [2:0] m_hs;
  bit       m_cap;

  always #10 clk = ~clk;

  lpm_dev_resp u0 (
    .clk(clk), .rst_n(rst_n), .lpm_rx_vld(vld), .lpm_link_state(ls),
    .lpm_mode(mode), .lpm_tx_en(tx_en), .tx_fifo_busy(txb), .rx_fifo_busy(rxb),
    .resume_evt(res), .stat_rd(rd), .hs_ack(ack), .hs_nyet(nyet), .hs_stall(stall),
    .attr_capture(cap), .stat_q(stat), .irq(irq));

  always @(posedge clk or negedge rst_n) begin
    bit [7:0] nb;
    if (!rst_n) begin
      m_stat = 0; m_hs = 0; m_cap = 0;
    end else begin
      nb = 0; m_hs = 0; m_cap = 0;
      if (res) nb = nb | 8'h10;
      if (vld && (mode == 2'd1 || mode == 2'd3)) begin
        m_cap = 1;
        if (ls != 4'h1) begin m_hs = 3'b001; nb = nb | 8'h20; end
        else if (mode == 2'd1) begin m_hs = 3'b001; nb = nb | 8'h01; end
        else if (tx_en == 0) begin m_hs = 3'b010; nb = nb | 8'h02; end
        else if (txb) begin m_hs = 3'b010; nb = nb | 8'h02; end
        else if (rxb) begin m_hs = 3'b010; nb = nb | 8'h08; end
        else begin m_hs = 3'b100; nb = nb | 8'h04; end
      end
      if (rd) m_stat = nb; else m_stat = m_stat | nb;
    end
  end

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("R12", {ack, nyet, stall}, m_hs, "handshake");
    chk("R12", cap, m_cap, "capture");
    chk(cur, stat, m_stat, "status");
    chk("R11", irq, (m_stat != 0), "irq");
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic tok(string req, logic [1:0] md, logic te, logic [3:0] st, logic tb_, logic rb);
    cur = req; mode = md; tx_en = te; ls = st; txb = tb_; rxb = rb; vld = 1;
    step(); vld = 0; step();
  endtask

  task automatic rdclr(string req);
    cur = req; rd = 1; step(); rd = 0; step();
  endtask

  initial begin
    cur = "R1";
    repeat (3) step();
    rst_n = 1;
    repeat (3) step();
    chk("R1", stat, 0, "reset status");
    chk("R1", {ack, nyet, stall, cap, irq}, 0, "reset outputs");

    tok("R3", 2'd1, 0, 4'h1, 0, 0);
    tok("R3", 2'd1, 1, 4'h1, 1, 1);
    rdclr("R2");
    tok("R4", 2'd3, 0, 4'h1, 0, 0);
    tok("R4", 2'd3, 0, 4'h1, 1, 1);
    rdclr("R2");
    tok("R5", 2'd3, 1, 4'h1, 0, 0);
    rdclr("R2");
    tok("R6", 2'd3, 1, 4'h1, 0, 1);
    rdclr("R2");
    tok("R7", 2'd3, 1, 4'h1, 1, 0);
    tok("R7", 2'd3, 1, 4'h1, 1, 1);
    rdclr("R2");
    for (int s = 0; s < 16; s++) begin
      tok("R8", 2'd1, 0, s[3:0], 0, 0);
      tok("R8", 2'd3, 1, s[3:0], 0, 0);
      rdclr("R8");
    end
    for (int s = 0; s < 4; s++) begin
      tok("R9", 2'd0, 1, 4'h1, s[0], s[1]);
      tok("R9", 2'd2, 1, 4'h1, s[0], s[1]);
      tok("R9", 2'd2, 0, 4'h5, s[0], s[1]);
    end
    cur = "R10"; res = 1; step(); res = 0; step();
    chk("R10", stat[4], 1, "resume bit");
    // read in the same cycle as a new token: new bit survives
    tok("R5", 2'd3, 1, 4'h1, 0, 0);
    cur = "R2"; rd = 1; mode = 2'd1; ls = 4'h1; vld = 1; step();
    rd = 0; vld = 0; step();
    chk("R2", stat, 8'h01, "read with simultaneous event");
    cur = "R2"; rd = 1; res = 1; step(); rd = 0; res = 0; step();
    chk("R2", stat, 8'h10, "read with simultaneous resume");
    rdclr("R2");
    chk("R11", irq, 0, "irq after clear");
    repeat (3) step();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule